// File: doc/BRIEF.md
# Clock Lane Burst Sequencer

This block steps the clock lane of a serial display or camera transmitter from low-power signalling into a free-running high-speed clock and back again. A lane-group controller raises `hs_req`. The sequencer then walks the lane through a fixed sequence: a low-power request state, a bridge state, a settled high-speed zero, and finally clock toggling. Each step lasts a programmable number of cycles. After the clock has run for the pre-interval, `data_ready` tells the data lanes that they may start their own entry.

When the data lanes have finished, the controller pulses `lane_release`. The clock keeps toggling for the post-interval and then holds high-speed zero for the trail interval. The lane then returns to the low-power stop state, where it stays for at least the exit interval before it honours another request. The block has no data path. Every pin is a plain level control or status, so no valid/ready back-pressure applies.

All durations are counted in cycles of `clk` by one shared down-counter, which is reloaded on every state change. A programmed value of 0 is treated as 1.

Top module: `dclk_lane_seq`

## Requirements
- R1: Out of reset, and whenever idle, `lp_drive` is 2'b11 (stop state; bit 1 is the positive line, bit 0 the negative line) and `hs_drive_en`, `hs_clk_en`, `data_ready` and `hs_ack` are all 0.
- R2: A high `hs_req` sampled while idle makes `lp_drive` 2'b01 from the next cycle, for exactly `cfg_lpx` cycles.
- R3: After the request state, `lp_drive` is 2'b00 with `hs_drive_en` low for exactly `cfg_prepare` cycles.
- R4: Then `hs_drive_en` is 1, `hs_clk_en` is 0 and `lp_drive` is 2'b00 (high-speed zero) for exactly `cfg_zero` cycles.
- R5: Then `hs_clk_en` is 1 with `data_ready` 0 for exactly `cfg_pre` cycles, after which `data_ready` rises.
- R6: `data_ready` stays high until `lane_release` is sampled high. From the next cycle `data_ready` is 0 and `hs_clk_en` stays 1 for exactly `cfg_post` cycles.
- R7: Then high-speed zero (`hs_drive_en` 1, `hs_clk_en` 0) is held for exactly `cfg_trail` cycles, after which `lp_drive` is 2'b11 with `hs_drive_en` 0.
- R8: The stop state following a burst lasts at least `cfg_exit` cycles. If `hs_req` is still high when that window ends, the next request state starts immediately, so the stop state lasts exactly `cfg_exit` cycles.
- R9: `lane_release` has no effect outside the `data_ready` phase, and `hs_req` has no effect once a burst has started. Dropping it mid-burst does not abort the sequence.
- R10: A duration input of 0 behaves as 1 cycle.
- R11: `hs_ack` is high from the first request-state cycle through the last cycle of the exit window, and is low otherwise.
- R12: `data_ready` implies `hs_clk_en`, `hs_clk_en` implies `hs_drive_en`, and `hs_drive_en` implies `lp_drive` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_req | input | 1 | Request for a high-speed clock burst |
| lane_release | input | 1 | Data lanes are back in low power; start clock shutdown |
| cfg_lpx | input | CW | Low-power request duration, cycles |
| cfg_prepare | input | CW | Bridge (LP-00) duration, cycles |
| cfg_zero | input | CW | High-speed zero before toggling, cycles |
| cfg_pre | input | CW | Clock run time before data lanes may start, cycles |
| cfg_post | input | CW | Clock run time after release, cycles |
| cfg_trail | input | CW | High-speed zero after the last clock bit, cycles |
| cfg_exit | input | CW | Minimum stop-state hold after a burst, cycles |
| hs_ack | output | 1 | Burst sequence in progress |
| data_ready | output | 1 | Data lanes may perform their entry |
| lp_drive | output | 2 | Low-power line state {P, N} |
| hs_drive_en | output | 1 | High-speed driver enable |
| hs_clk_en | output | 1 | High-speed clock gate enable |

## Verification
The bench builds the block with `CW` = 6. That width keeps every duration short while leaving room for distinct lengths per phase, so any swap between two windows shows up as a wrong run length. Each phase is measured as the run length of its distinct output pattern. The cases covered are asymmetric durations, all-zero durations (each phase collapses to one cycle), back-to-back bursts with `hs_req` held so that the exit window is measured exactly, and a release held across the bridge phase that must be ignored.

// File: rtl/dclk_pkg.sv
package dclk_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ,
    ST_PREP,
    ST_ZERO,
    ST_PRE,
    ST_RUN,
    ST_POST,
    ST_TRAIL,
    ST_EXIT
  } clk_st_e;

  localparam logic [1:0] LP_STOP   = 2'b11;
  localparam logic [1:0] LP_REQ    = 2'b01;
  localparam logic [1:0] LP_BRIDGE = 2'b00;
endpackage

// File: rtl/dclk_timer.sv
module dclk_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= ONE;
    end else if (load) begin
      cnt <= (load_val == '0) ? ONE : load_val;
    end else if (cnt > ONE) begin
      cnt <= cnt - ONE;
    end
  end

  assign expire = (cnt == ONE);
endmodule

// File: rtl/dclk_fsm.sv
module dclk_fsm
  import dclk_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_req,
  input  logic          lane_release,
  input  logic          expire,
  input  logic [CW-1:0] cfg_lpx,
  input  logic [CW-1:0] cfg_prepare,
  input  logic [CW-1:0] cfg_zero,
  input  logic [CW-1:0] cfg_pre,
  input  logic [CW-1:0] cfg_post,
  input  logic [CW-1:0] cfg_trail,
  input  logic [CW-1:0] cfg_exit,
  output clk_st_e       state,
  output logic          load,
  output logic [CW-1:0] load_val
);
  clk_st_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (hs_req)       nxt = ST_REQ;
      ST_REQ:   if (expire)       nxt = ST_PREP;
      ST_PREP:  if (expire)       nxt = ST_ZERO;
      ST_ZERO:  if (expire)       nxt = ST_PRE;
      ST_PRE:   if (expire)       nxt = ST_RUN;
      ST_RUN:   if (lane_release) nxt = ST_POST;
      ST_POST:  if (expire)       nxt = ST_TRAIL;
      ST_TRAIL: if (expire)       nxt = ST_EXIT;
      ST_EXIT:  if (expire)       nxt = hs_req ? ST_REQ : ST_IDLE;
      default:                    nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (nxt)
      ST_REQ:   load_val = cfg_lpx;
      ST_PREP:  load_val = cfg_prepare;
      ST_ZERO:  load_val = cfg_zero;
      ST_PRE:   load_val = cfg_pre;
      ST_POST:  load_val = cfg_post;
      ST_TRAIL: load_val = cfg_trail;
      ST_EXIT:  load_val = cfg_exit;
      default:  load_val = '0;
    endcase
  end

  assign load = (nxt != state);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/dclk_outdec.sv
module dclk_outdec
  import dclk_pkg::*;
(
  input  clk_st_e    state,
  output logic [1:0] lp_drive,
  output logic       hs_drive_en,
  output logic       hs_clk_en,
  output logic       data_ready,
  output logic       hs_ack
);
  always_comb begin
    lp_drive    = LP_BRIDGE;
    hs_drive_en = 1'b0;
    hs_clk_en   = 1'b0;
    data_ready  = 1'b0;
    hs_ack      = 1'b1;
    unique case (state)
      ST_IDLE:  begin lp_drive = LP_STOP; hs_ack = 1'b0; end
      ST_REQ:   lp_drive = LP_REQ;
      ST_PREP:  lp_drive = LP_BRIDGE;
      ST_ZERO,
      ST_TRAIL: hs_drive_en = 1'b1;
      ST_PRE,
      ST_POST:  begin hs_drive_en = 1'b1; hs_clk_en = 1'b1; end
      ST_RUN:   begin hs_drive_en = 1'b1; hs_clk_en = 1'b1; data_ready = 1'b1; end
      ST_EXIT:  lp_drive = LP_STOP;
      default:  begin lp_drive = LP_STOP; hs_ack = 1'b0; end
    endcase
  end
endmodule

// File: rtl/dclk_lane_seq.sv
module dclk_lane_seq
  import dclk_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_req,
  input  logic          lane_release,
  input  logic [CW-1:0] cfg_lpx,
  input  logic [CW-1:0] cfg_prepare,
  input  logic [CW-1:0] cfg_zero,
  input  logic [CW-1:0] cfg_pre,
  input  logic [CW-1:0] cfg_post,
  input  logic [CW-1:0] cfg_trail,
  input  logic [CW-1:0] cfg_exit,
  output logic          hs_ack,
  output logic          data_ready,
  output logic [1:0]    lp_drive,
  output logic          hs_drive_en,
  output logic          hs_clk_en
);
  clk_st_e       state;
  logic          load;
  logic          expire;
  logic [CW-1:0] load_val;

  dclk_fsm #(.CW(CW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .hs_req       (hs_req),
    .lane_release (lane_release),
    .expire       (expire),
    .cfg_lpx      (cfg_lpx),
    .cfg_prepare  (cfg_prepare),
    .cfg_zero     (cfg_zero),
    .cfg_pre      (cfg_pre),
    .cfg_post     (cfg_post),
    .cfg_trail    (cfg_trail),
    .cfg_exit     (cfg_exit),
    .state        (state),
    .load         (load),
    .load_val     (load_val)
  );

  dclk_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .expire   (expire)
  );

  dclk_outdec u_dec (
    .state       (state),
    .lp_drive    (lp_drive),
    .hs_drive_en (hs_drive_en),
    .hs_clk_en   (hs_clk_en),
    .data_ready  (data_ready),
    .hs_ack      (hs_ack)
  );
endmodule

// File: rtl/dclk_lane_chk.sv
module dclk_lane_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lane_release,
  input logic       hs_ack,
  input logic       data_ready,
  input logic [1:0] lp_drive,
  input logic       hs_drive_en,
  input logic       hs_clk_en
);
  AST_READY_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> hs_clk_en && hs_drive_en); // R12

  AST_CLK_NEEDS_HS: assert property (@(posedge clk) disable iff (!rst_n)
    hs_clk_en |-> hs_drive_en && lp_drive == 2'b00); // R12

  AST_REQ_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_drive == 2'b01 && $past(lp_drive) != 2'b01) |-> $past(lp_drive) == 2'b11); // R2

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready && !lane_release |=> data_ready); // R6

  AST_READY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready && lane_release |=> !data_ready && hs_clk_en); // R6

  AST_HS_AFTER_BRIDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_drive_en) |-> $past(lp_drive) == 2'b00 && !hs_clk_en); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_ack |-> lp_drive == 2'b11 && !hs_drive_en); // R1
endmodule

bind dclk_lane_seq dclk_lane_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lane_release (lane_release),
  .hs_ack       (hs_ack),
  .data_ready   (data_ready),
  .lp_drive     (lp_drive),
  .hs_drive_en  (hs_drive_en),
  .hs_clk_en    (hs_clk_en)
);

// File: tb/sim_dclk_lane_seq.sv
`timescale 1ns/1ps
module sim_dclk_lane_seq;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_req = 1'b0;
  logic lane_release = 1'b0;
  logic [CW-1:0] c_lpx = '0, c_prep = '0, c_zero = '0, c_pre = '0;
  logic [CW-1:0] c_post = '0, c_trail = '0, c_exit = '0;
  logic hs_ack, data_ready, hs_drive_en, hs_clk_en;
  logic [1:0] lp_drive;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dclk_lane_seq #(.CW(CW)) u0 (
    .clk (clk), .rst_n (rst_n), .hs_req (hs_req), .lane_release (lane_release),
    .cfg_lpx (c_lpx), .cfg_prepare (c_prep), .cfg_zero (c_zero), .cfg_pre (c_pre),
    .cfg_post (c_post), .cfg_trail (c_trail), .cfg_exit (c_exit),
    .hs_ack (hs_ack), .data_ready (data_ready), .lp_drive (lp_drive),
    .hs_drive_en (hs_drive_en), .hs_clk_en (hs_clk_en)
  );

  // 0 stop, 1 request, 2 bridge, 3 hs-zero, 4 clock w/o ready, 5 clock+ready, 7 illegal
  function automatic int phase();
    if (!hs_drive_en) begin
      if (lp_drive == 2'b11) return 0;
      if (lp_drive == 2'b01) return 1;
      if (lp_drive == 2'b00) return 2;
      return 7;
    end
    if (!hs_clk_en) return 3;
    return data_ready ? 5 : 4;
  endfunction

  function automatic int eff(logic [CW-1:0] v);
    return (v == '0) ? 1 : int'(v);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic measure(int code, int exp, string tag);
    int n = 0;
    while (phase() == code && n < 500) begin
      n++;
      @(negedge clk);
    end
    chk(n == exp, tag, n, exp);
  endtask

  task automatic set_cfg(int lpx, int prep, int zero, int pre, int post, int trail, int ex);
    c_lpx = CW'(lpx); c_prep = CW'(prep); c_zero = CW'(zero); c_pre = CW'(pre);
    c_post = CW'(post); c_trail = CW'(trail); c_exit = CW'(ex);
  endtask

  // From first request-state negedge through end of trail.
  task automatic run_phases(bit drop_req, bit rel_early, int run_len, string tg);
    chk(hs_ack == 1'b1, {tg, " R11 ack at request"}, int'(hs_ack), 1);
    measure(1, eff(c_lpx), {tg, " R2 request length"});
    if (drop_req) hs_req = 1'b0;          // R9: must not abort
    lane_release = rel_early;             // R9: ignored in bridge phase
    measure(2, eff(c_prep), {tg, " R3 bridge length"});
    lane_release = 1'b0;
    measure(3, eff(c_zero), {tg, " R4 hs-zero length"});
    measure(4, eff(c_pre), {tg, " R5 pre length"});
    for (int i = 0; i < run_len; i++) begin
      chk(phase() == 5, {tg, " R6 ready held"}, phase(), 5);
      if (i < run_len - 1) @(negedge clk);
    end
    lane_release = 1'b1;
    @(negedge clk);
    lane_release = 1'b0;
    measure(4, eff(c_post), {tg, " R6 post length"});
    measure(3, eff(c_trail), {tg, " R7 trail length"});
    chk(phase() == 0, {tg, " R7 back to stop"}, phase(), 0);
  endtask

  task automatic wait_exit(string tg);
    int n = 0;
    while (hs_ack && phase() == 0 && n < 500) begin
      n++;
      @(negedge clk);
    end
    chk(n == eff(c_exit), {tg, " R11 ack through exit"}, n, eff(c_exit));
    chk(phase() == 0 && !hs_ack, {tg, " R1 idle after exit"}, phase(), 0);
  endtask

  task automatic t_reset();
    chk(lp_drive == 2'b11 && !hs_drive_en && !hs_clk_en && !data_ready && !hs_ack,
        "R1 reset outputs", int'(lp_drive), 3);
  endtask

  task automatic t_basic();
    set_cfg(3, 2, 4, 5, 3, 2, 4);
    hs_req = 1'b1;
    @(negedge clk);
    run_phases(1'b1, 1'b0, 3, "basic");
    wait_exit("basic");
  endtask

  task automatic t_zero_counts();
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    hs_req = 1'b1;
    @(negedge clk);
    run_phases(1'b1, 1'b0, 1, "R10 zeros");
    wait_exit("R10 zeros");
  endtask

  task automatic t_back_to_back();
    set_cfg(2, 3, 1, 2, 4, 3, 6);
    hs_req = 1'b1;
    @(negedge clk);
    run_phases(1'b0, 1'b0, 2, "b2b1");
    measure(0, eff(c_exit), "R8 exit hold exact");
    chk(phase() == 1, "R8 re-entry after exit", phase(), 1);
    run_phases(1'b1, 1'b0, 4, "b2b2");
    wait_exit("b2b2");
  endtask

  task automatic t_release_early();
    set_cfg(1, 4, 2, 3, 2, 1, 2);
    hs_req = 1'b1;
    @(negedge clk);
    run_phases(1'b1, 1'b1, 5, "R9 early release");
    wait_exit("R9 early release");
    repeat (3) @(negedge clk);
    chk(phase() == 0 && !hs_ack, "R9 req low stays idle", phase(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_zero_counts();
    t_back_to_back();
    t_release_early();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule